// File: doc/BRIEF.md
# Port Power-On Fault Supervisor

This block supervises one power port from the moment a turn-on command arrives. It raises a gate-ramp request and holds the port in an inrush phase for a fixed number of system ticks. When that window closes it checks whether the inrush comparator still reports current at the limit. If so, the port is shut off and a start fault is latched. If not, the port moves to the powered phase.

In the powered phase, two overcurrent comparators are watched: the cut level and the hard limit. Each has its own tick counter. A counter restarts whenever its flag drops. When a counter fills, the port is shut off and the matching fault code is latched. The threshold codes written by the host are passed through a register to the analog threshold circuits in every phase, so they can be changed while the port is powered. A latched fault blocks any new turn-on until the host clears it. A turn-off command always returns the port to off without recording a fault.

Top module: `pwr_port_supervisor`

## Requirements
- R1: While `rst` is high, on the following clock edge the phase is OFF (`phase_o` = 2'b00), `gate_req_o` is 0, `fault_o` is 2'b00 and both forwarded codes are 0.
- R2: In OFF with no fault latched, a turn-on command without a turn-off command moves the port to INRUSH (`phase_o` = 2'b01) with `gate_req_o` = 1 one clock later.
- R3: The INRUSH phase lasts exactly START_TICKS ticks, whatever the inrush flag does before the last of them. Cycles with `tick_i` low do not advance any timer.
- R4: If the inrush flag is high on the tick that ends the inrush window, the port goes to OFF with the gate dropped and latches fault 2'b01. Otherwise it goes to ON (`phase_o` = 2'b10).
- R5: In ON, CUT_TICKS consecutive ticks with the cut flag high turn the port off and latch fault 2'b10. A tick with the flag low restarts the count.
- R6: In ON, LIM_TICKS consecutive ticks with the limit flag high turn the port off and latch fault 2'b11. If both timers fill on the same tick, the code is 2'b11.
- R7: A nonzero fault code holds until `fault_clr_i` is pulsed. While it is held, turn-on commands are ignored and the port stays OFF.
- R8: A turn-off command in INRUSH or ON gives OFF with `gate_req_o` = 0 and fault 2'b00 one clock later. It wins over a timer filling on the same tick.
- R9: `cut_code_o` and `lim_code_o` equal the values of `cut_code_i` and `lim_code_i` at the previous clock edge, in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | System tick strobe that advances the timers |
| on_cmd_i | input | 1 | Turn-on command |
| off_cmd_i | input | 1 | Turn-off command |
| fault_clr_i | input | 1 | Host clear of the latched fault |
| inrush_ovc_i | input | 1 | Current at the inrush limit |
| cut_ovc_i | input | 1 | Current above the cut threshold |
| lim_ovc_i | input | 1 | Current above the hard limit threshold |
| cut_code_i | input | CODE_W | Host cut threshold code |
| lim_code_i | input | CODE_W | Host limit threshold code |
| gate_req_o | output | 1 | Gate ramp request |
| phase_o | output | 2 | 00 OFF, 01 INRUSH, 10 ON |
| fault_o | output | 2 | 00 none, 01 start, 10 cut, 11 limit |
| cut_code_o | output | CODE_W | Registered cut threshold code |
| lim_code_o | output | CODE_W | Registered limit threshold code |

## Verification
Some rules are checked by the assertions on every cycle:
- acceptance of a turn-on;
- the lock-out while a fault is held;
- the hold of a latched code;
- the priority of turn-off;
- start-fault capture;
- the precedence of the limit code;
- code forwarding.

Other behaviour shows only in the bench's scenarios:
- the exact tick at which each window closes;
- the restart of the cut count when its flag drops;
- the two timers filling on the same tick;
- a turn-off landing on the tick that would have faulted;
- the inrush phase surviving long gaps between ticks.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PH_OFF    = 2'b00,
    PH_INRUSH = 2'b01,
    PH_ON     = 2'b10
  } pps_phase_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_START = 2'b01,
    FLT_CUT   = 2'b10,
    FLT_LIM   = 2'b11
  } pps_fault_e;

  localparam int unsigned NUM_TIMERS = 3;
  localparam int unsigned TMR_START  = 0;
  localparam int unsigned TMR_CUT    = 1;
  localparam int unsigned TMR_LIM    = 2;

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic expire
);

  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count;

  assign expire = run && tick && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
    end else if (tick) begin
      if (expire) count <= '0;
      else        count <= count + 1'b1;
    end
  end

  // R3: the count never passes the last step of its window
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);

endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       on_cmd,
  input  logic       off_cmd,
  input  logic       fault_clr,
  input  logic       inrush_ovc,
  input  logic       exp_start,
  input  logic       exp_cut,
  input  logic       exp_lim,
  output pps_phase_e phase,
  output logic       gate,
  output pps_fault_e fault
);

  pps_phase_e phase_n;
  logic       gate_n;
  pps_fault_e fault_n;

  always_comb begin
    phase_n = phase;
    gate_n  = gate;
    fault_n = fault;
    if (fault_clr) fault_n = FLT_NONE;
    unique case (phase)
      PH_OFF: begin
        if (on_cmd && !off_cmd && fault == FLT_NONE) begin
          phase_n = PH_INRUSH;
          gate_n  = 1'b1;
        end
      end
      PH_INRUSH: begin
        if (off_cmd) begin
          phase_n = PH_OFF;
          gate_n  = 1'b0;
        end else if (exp_start) begin
          if (inrush_ovc) begin
            phase_n = PH_OFF;
            gate_n  = 1'b0;
            fault_n = FLT_START;
          end else begin
            phase_n = PH_ON;
          end
        end
      end
      PH_ON: begin
        if (off_cmd) begin
          phase_n = PH_OFF;
          gate_n  = 1'b0;
        end else if (exp_lim) begin
          phase_n = PH_OFF;
          gate_n  = 1'b0;
          fault_n = FLT_LIM;
        end else if (exp_cut) begin
          phase_n = PH_OFF;
          gate_n  = 1'b0;
          fault_n = FLT_CUT;
        end
      end
      default: begin
        phase_n = PH_OFF;
        gate_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OFF;
      gate  <= 1'b0;
      fault <= FLT_NONE;
    end else begin
      phase <= phase_n;
      gate  <= gate_n;
      fault <= fault_n;
    end
  end

  // R2: an accepted turn-on enters inrush with the gate raised
  p_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OFF && on_cmd && !off_cmd && fault == FLT_NONE)
      |=> (phase == PH_INRUSH && gate));

  // R4: inrush still at limit when the window closes gives a start fault
  p_start_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INRUSH && exp_start && inrush_ovc && !off_cmd)
      |=> (phase == PH_OFF && !gate && fault == FLT_START));

  // R6: the limit timer outranks the cut timer
  p_lim_prio_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ON && exp_lim && !off_cmd) |=> (fault == FLT_LIM));

  // R7: a latched code holds until cleared
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fault != FLT_NONE && !fault_clr) |=> (fault == $past(fault)));

  // R7: no turn-on while a fault is latched
  p_locked_off_r7: assert property (@(posedge clk) disable iff (rst)
    (fault != FLT_NONE && phase == PH_OFF) |=> (phase == PH_OFF && !gate));

  // R8: turn-off wins and records nothing
  p_off_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (off_cmd && phase != PH_OFF)
      |=> (phase == PH_OFF && !gate && fault == FLT_NONE));

endmodule

// File: rtl/pwr_port_supervisor.sv
module pwr_port_supervisor
  import pps_pkg::*;
#(
  parameter int unsigned START_TICKS = 60,
  parameter int unsigned CUT_TICKS   = 60,
  parameter int unsigned LIM_TICKS   = 12,
  parameter int unsigned CODE_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              on_cmd_i,
  input  logic              off_cmd_i,
  input  logic              fault_clr_i,
  input  logic              inrush_ovc_i,
  input  logic              cut_ovc_i,
  input  logic              lim_ovc_i,
  input  logic [CODE_W-1:0] cut_code_i,
  input  logic [CODE_W-1:0] lim_code_i,
  output logic              gate_req_o,
  output logic [1:0]        phase_o,
  output logic [1:0]        fault_o,
  output logic [CODE_W-1:0] cut_code_o,
  output logic [CODE_W-1:0] lim_code_o
);

  pps_phase_e            phase;
  pps_fault_e            fault;
  logic                  gate;
  logic [NUM_TIMERS-1:0] run;
  logic [NUM_TIMERS-1:0] expire;

  assign run[TMR_START] = (phase == PH_INRUSH);
  assign run[TMR_CUT]   = (phase == PH_ON) && cut_ovc_i;
  assign run[TMR_LIM]   = (phase == PH_ON) && lim_ovc_i;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam int unsigned WIN = (i == TMR_START) ? START_TICKS :
                                  (i == TMR_CUT)   ? CUT_TICKS   : LIM_TICKS;
    pps_tick_timer #(.LIMIT(WIN)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_i),
      .run    (run[i]),
      .expire (expire[i])
    );
  end

  pps_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .on_cmd     (on_cmd_i),
    .off_cmd    (off_cmd_i),
    .fault_clr  (fault_clr_i),
    .inrush_ovc (inrush_ovc_i),
    .exp_start  (expire[TMR_START]),
    .exp_cut    (expire[TMR_CUT]),
    .exp_lim    (expire[TMR_LIM]),
    .phase      (phase),
    .gate       (gate),
    .fault      (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_code_o <= '0;
      lim_code_o <= '0;
    end else begin
      cut_code_o <= cut_code_i;
      lim_code_o <= lim_code_i;
    end
  end

  assign gate_req_o = gate;
  assign phase_o    = phase;
  assign fault_o    = fault;

  // R9: threshold codes reach the outputs one edge later in any phase
  p_code_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cut_code_o == $past(cut_code_i) && lim_code_o == $past(lim_code_i)));

endmodule

// File: tb/sim_pwr_port_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_port_supervisor;

  localparam int unsigned ST = 4;
  localparam int unsigned CT = 5;
  localparam int unsigned LT = 3;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0, on_cmd_i = 1'b0, off_cmd_i = 1'b0, fault_clr_i = 1'b0;
  logic          inrush_ovc_i = 1'b0, cut_ovc_i = 1'b0, lim_ovc_i = 1'b0;
  logic [CW-1:0] cut_code_i = '0, lim_code_i = '0;
  logic          gate_req_o;
  logic [1:0]    phase_o, fault_o;
  logic [CW-1:0] cut_code_o, lim_code_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_port_supervisor #(.START_TICKS(ST), .CUT_TICKS(CT), .LIM_TICKS(LT), .CODE_W(CW)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .on_cmd_i(on_cmd_i), .off_cmd_i(off_cmd_i),
    .fault_clr_i(fault_clr_i), .inrush_ovc_i(inrush_ovc_i), .cut_ovc_i(cut_ovc_i),
    .lim_ovc_i(lim_ovc_i), .cut_code_i(cut_code_i), .lim_code_i(lim_code_i),
    .gate_req_o(gate_req_o), .phase_o(phase_o), .fault_o(fault_o),
    .cut_code_o(cut_code_o), .lim_code_o(lim_code_o));

  // stimulus bits: on off clr inr cut lim tick | expected phase(2) gate fault(2)
  localparam int NV = 34;
  localparam logic [11:0] VEC [0:NV-1] = '{
    12'b1000001_01_1_00, 12'b0001001_01_1_00, 12'b0000001_01_1_00, 12'b0000001_01_1_00,
    12'b0000001_10_1_00, 12'b0000101_10_1_00, 12'b0000101_10_1_00, 12'b0000101_10_1_00,
    12'b0000101_10_1_00, 12'b0000001_10_1_00, 12'b0000101_10_1_00, 12'b0000101_10_1_00,
    12'b0000101_10_1_00, 12'b0000101_10_1_00, 12'b0000101_00_0_10, 12'b1000001_00_0_10,
    12'b0010001_00_0_00, 12'b1000001_01_1_00, 12'b0001001_01_1_00, 12'b0001001_01_1_00,
    12'b0001001_01_1_00, 12'b0001001_00_0_01, 12'b0010001_00_0_00, 12'b1000001_01_1_00,
    12'b0000001_01_1_00, 12'b0000001_01_1_00, 12'b0000001_01_1_00, 12'b0000001_10_1_00,
    12'b0000011_10_1_00, 12'b0000011_10_1_00, 12'b0000011_00_0_11, 12'b0010001_00_0_00,
    12'b1000001_01_1_00, 12'b0100001_00_0_00
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] s);
    @(negedge clk);
    {on_cmd_i, off_cmd_i, fault_clr_i, inrush_ovc_i, cut_ovc_i, lim_ovc_i, tick_i} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input string tag, input int ph, input int g, input int f);
    chk({tag, " phase"}, int'(phase_o), ph);
    chk({tag, " gate"},  int'(gate_req_o), g);
    chk({tag, " fault"}, int'(fault_o), f);
  endtask

  task automatic power_up();
    step(7'b1000001);
    for (int k = 0; k < ST; k++) step(7'b0000001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, with busy inputs
    cut_code_i = 4'h7; lim_code_i = 4'h9;
    @(negedge clk); on_cmd_i = 1'b1; tick_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_state("R1 reset", 0, 0, 0);
    chk("R1 reset cut code", int'(cut_code_o), 0);
    chk("R1 reset lim code", int'(lim_code_o), 0);
    @(negedge clk); rst = 1'b0; on_cmd_i = 1'b0; cut_code_i = '0; lim_code_i = '0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:5]);
      expect_state($sformatf("table row %0d (R2/R3/R4/R5/R6/R7/R8)", i),
                   int'(VEC[i][4:3]), int'(VEC[i][2]), int'(VEC[i][1:0]));
    end

    // R3: no ticks means no progress through inrush
    step(7'b1000000);
    for (int k = 0; k < 10; k++) step(7'b0001000);
    expect_state("R3 tick gap", 1, 1, 0);
    for (int k = 0; k < ST - 1; k++) step(7'b0000001);
    expect_state("R3 last tick pending", 1, 1, 0);
    step(7'b0000001);
    expect_state("R3 window closed", 2, 1, 0);

    // R9: codes forwarded while powered
    @(negedge clk); cut_code_i = 4'hA; lim_code_i = 4'h5;
    step(7'b0000001);
    chk("R9 cut code on", int'(cut_code_o), 10);
    chk("R9 lim code on", int'(lim_code_o), 5);

    // R6: both timers fill on the same tick
    step(7'b0000101);
    step(7'b0000101);
    step(7'b0000111);
    step(7'b0000111);
    expect_state("R6 before both fill", 2, 1, 0);
    step(7'b0000111);
    expect_state("R6 both fill", 0, 0, 3);
    step(7'b0010000);
    expect_state("R7 cleared", 0, 0, 0);

    // R8: turn-off on the tick that would fault
    power_up();
    for (int k = 0; k < CT - 1; k++) step(7'b0000101);
    step(7'b0100101);
    expect_state("R8 off beats cut", 0, 0, 0);

    // R9: codes forwarded while off
    @(negedge clk); cut_code_i = 4'h3; lim_code_i = 4'hC;
    step(7'b0000000);
    chk("R9 cut code off", int'(cut_code_o), 3);
    chk("R9 lim code off", int'(lim_code_o), 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule